// File: doc/BRIEF.md
# I2C Master Write Engine

This block is a bus master that carries out one complete write transfer on a two-wire open-drain serial bus. A request gives an address byte, whose bit 0 must be 0 for a write, and a byte count of up to 255. The payload bytes are then pulled one at a time through a valid/ready stream while the transfer runs. The engine first checks that the bus is idle. It then issues START, sends the address byte and each payload byte most significant bit first, and reads the acknowledge after every byte. It finishes with STOP. When it is done it raises a one-cycle `done` together with a status code and the number of payload bytes the target acknowledged.

The engine never drives a line high. For each line it has an enable that pulls the line low, and it reads the resolved level back through a separate input. This readback lets the engine follow a target that holds the clock low. It also lets the engine detect that another master has won the data line. All phase lengths are cycle counts derived from `CLK_PER_US`. A clock that is held low longer than `STRETCH_MAX` cycles ends the transfer with a timeout.

Top module: `i2c_wr_master`

## Requirements
- R1: A request whose address bit 0 is 1 completes one cycle after acceptance with status 0x20 and count 0, and neither line is pulled.
- R2: A write request whose count is above 255 completes one cycle after acceptance with status 0x40, and neither line is pulled.
- R3: If SCL or SDA reads low at any cycle of the idle-check window (at least 4.7 us), the transfer ends with status 0x01 and neither line is pulled.
- R4: START pulls SDA low while SCL is high, and SCL stays released for at least 4.7 us after SDA falls.
- R5: The address byte and then each payload byte in stream order are sent MSB first. SDA is changed only while the engine holds SCL low, except for START and STOP.
- R6: After releasing SCL the engine waits until SCL reads high, and every SCL high phase lasts at least 4.0 us measured from that moment.
- R7: If the engine reads SDA low while SCL is high and it is sending a 1 data bit, it releases both lines, sends no STOP and reports status 0x08.
- R8: A high SDA during the high phase of the address acknowledge clock gives status 0x02 with count 0, followed by STOP.
- R9: A high SDA during a payload acknowledge clock gives status 0x04 with the count of payload bytes acknowledged before it, followed by STOP.
- R10: A transfer in which every byte is acknowledged ends with STOP, status 0x00 and count equal to the requested count (0 allowed). Both lines are released whenever `done` is high.
- R11: If SCL stays low for more than `STRETCH_MAX` cycles after the engine releases it, both lines are released and status 0x10 is reported.
- R12: `req_ready` is high only while the engine is idle, and the lines are released then. Each payload byte is taken by exactly one `data_valid`/`data_ready` handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Engine idle, request accepted |
| req_addr | input | 8 | Address byte: 7-bit address in bits 7:1, direction in bit 0 |
| req_count | input | CNT_W | Number of payload bytes |
| data_valid | input | 1 | Payload byte valid |
| data_ready | output | 1 | Engine takes a payload byte |
| data_byte | input | 8 | Payload byte |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Completion code, valid with done |
| xfer_count | output | 8 | Payload bytes acknowledged, valid with done |

## Verification
The hardest condition to reach is a second master that wins arbitration. A target acknowledge cannot produce it, because the engine must be releasing SDA for a 1 during a high clock phase. The bench adds a competing driver that pulls SDA low as soon as the engine's START is seen. It sends an address whose first bit is 1, so the loss comes on the first high phase. Clock stretching and timeout also need an outside party on SCL. The target model holds SCL low for longer than the engine's own low phase after every falling edge. For the timeout case, a separate driver clamps SCL low once the engine first pulls it.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int MAX_BYTES = 255;

    typedef enum logic [7:0] {
        ST_OK      = 8'h00,
        ST_BUSY    = 8'h01,
        ST_NOADDR  = 8'h02,
        ST_NACK    = 8'h04,
        ST_ARB     = 8'h08,
        ST_TMO     = 8'h10,
        ST_BADADDR = 8'h20,
        ST_BADLEN  = 8'h40
    } st_code_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_FREE, PH_START, PH_LOW_A, PH_LOW_B, PH_WAIT_HI,
        PH_HIGH, PH_FETCH, PH_SP_A, PH_SP_B, PH_SP_C, PH_SP_D, PH_SP_E
    } phase_e;

    typedef struct packed {
        phase_e   state;
        logic     scl_oe;
        logic     sda_oe;
        logic [3:0] bitn;      // 0..7 data bits, 8 = acknowledge clock
        logic     is_addr;
        logic [7:0] remain;
        logic [7:0] sent;
        logic     nack;
        st_code_e pend;
        logic     done;
        st_code_e status;
    } ctl_t;

    // cycles covering a time given in tenths of a microsecond, rounded up
    function automatic int tenths_to_cyc(int tenths, int clk_per_us);
        return (tenths * clk_per_us + 9) / 10;
    endfunction

    function automatic ctl_t wrap_up(ctl_t x, st_code_e code);
        ctl_t y = x;
        y.done   = 1'b1;
        y.status = code;
        y.scl_oe = 1'b0;
        y.sda_oe = 1'b0;
        y.state  = PH_IDLE;
        return y;
    endfunction

endpackage

// File: rtl/i2cw_tick.sv
module i2cw_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/i2cw_shift.sv
module i2cw_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)        sr <= '0;
        else if (load)  sr <= din;
        else if (shift) sr <= {sr[W-2:0], 1'b0};
    end

    assign msb = sr[W-1];
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
    import i2cw_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int STRETCH_MAX = 100000,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_addr,
    input  logic [CNT_W-1:0] req_count,
    input  logic             data_valid,
    output logic             data_ready,
    input  logic [7:0]       data_byte,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             done,
    output logic [7:0]       status,
    output logic [7:0]       xfer_count
);
    localparam int T_SETUP = tenths_to_cyc(47, CLK_PER_US);
    localparam int T_HALF  = (T_SETUP + 1) / 2;
    localparam int T_HIGH  = tenths_to_cyc(40, CLK_PER_US);
    localparam int TMAX    = (STRETCH_MAX > T_SETUP) ? STRETCH_MAX : T_SETUP;
    localparam int TW      = $clog2(TMAX + 1);

    ctl_t q, c;
    logic          t_ld, t_exp, s_ld, s_exp;
    logic [TW-1:0] t_val;
    logic          sh_ld, sh_sh, sh_msb;
    logic [7:0]    sh_din;
    logic          nack_now;

    i2cw_tick #(.W(TW)) u_phase (
        .clk(clk), .rst(rst), .load(t_ld), .val(t_val), .expired(t_exp));

    i2cw_tick #(.W(TW)) u_stretch (
        .clk(clk), .rst(rst), .load(s_ld), .val(TW'(STRETCH_MAX)), .expired(s_exp));

    i2cw_shift #(.W(8)) u_sh (
        .clk(clk), .rst(rst), .load(sh_ld), .din(sh_din), .shift(sh_sh), .msb(sh_msb));

    assign nack_now = q.nack | sda_in;

    always_comb begin
        c          = q;
        c.done     = 1'b0;
        t_ld       = 1'b0;
        t_val      = TW'(T_HALF);
        s_ld       = 1'b0;
        sh_ld      = 1'b0;
        sh_sh      = 1'b0;
        sh_din     = req_addr;
        req_ready  = 1'b0;
        data_ready = 1'b0;
        case (q.state)
            PH_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    c.sent = '0;
                    if (req_addr[0])
                        c = wrap_up(c, ST_BADADDR);
                    else if (int'(req_count) > MAX_BYTES)
                        c = wrap_up(c, ST_BADLEN);
                    else begin
                        c.state   = PH_FREE;
                        c.remain  = req_count[7:0];
                        c.is_addr = 1'b1;
                        c.bitn    = '0;
                        sh_ld     = 1'b1;
                        t_ld      = 1'b1;
                        t_val     = TW'(T_SETUP);
                    end
                end
            end
            PH_FREE: begin
                if (!scl_in || !sda_in) c = wrap_up(c, ST_BUSY);
                else if (t_exp) begin
                    c.sda_oe = 1'b1;
                    c.state  = PH_START;
                    t_ld     = 1'b1;
                    t_val    = TW'(T_SETUP);
                end
            end
            PH_START: if (t_exp) begin
                c.scl_oe = 1'b1;
                c.state  = PH_LOW_A;
                t_ld     = 1'b1;
            end
            PH_LOW_A: if (t_exp) begin
                c.sda_oe = (q.bitn == 4'd8) ? 1'b0 : ~sh_msb;
                c.state  = PH_LOW_B;
                t_ld     = 1'b1;
            end
            PH_LOW_B: if (t_exp) begin
                c.scl_oe = 1'b0;
                c.state  = PH_WAIT_HI;
                s_ld     = 1'b1;
            end
            PH_WAIT_HI: begin
                if (scl_in) begin
                    c.state = PH_HIGH;
                    c.nack  = 1'b0;
                    t_ld    = 1'b1;
                    t_val   = TW'(T_HIGH);
                end else if (s_exp) c = wrap_up(c, ST_TMO);
            end
            PH_HIGH: begin
                if (q.bitn != 4'd8 && !q.sda_oe && !sda_in)
                    c = wrap_up(c, ST_ARB);
                else begin
                    if (q.bitn == 4'd8 && sda_in) c.nack = 1'b1;
                    if (t_exp) begin
                        c.scl_oe = 1'b1;
                        t_ld     = 1'b1;
                        if (q.bitn != 4'd8) begin
                            c.bitn  = q.bitn + 4'd1;
                            sh_sh   = 1'b1;
                            c.state = PH_LOW_A;
                        end else if (nack_now) begin
                            c.pend  = q.is_addr ? ST_NOADDR : ST_NACK;
                            c.state = PH_SP_A;
                        end else begin
                            if (!q.is_addr) c.sent = q.sent + 8'd1;
                            c.is_addr = 1'b0;
                            c.pend    = ST_OK;
                            c.state   = (q.remain == '0) ? PH_SP_A : PH_FETCH;
                        end
                    end
                end
            end
            PH_FETCH: begin
                data_ready = 1'b1;
                if (data_valid) begin
                    sh_din   = data_byte;
                    sh_ld    = 1'b1;
                    c.remain = q.remain - 8'd1;
                    c.bitn   = '0;
                    c.state  = PH_LOW_A;
                    t_ld     = 1'b1;
                end
            end
            PH_SP_A: if (t_exp) begin
                c.sda_oe = 1'b1;
                c.state  = PH_SP_B;
                t_ld     = 1'b1;
                t_val    = TW'(T_SETUP);
            end
            PH_SP_B: if (t_exp) begin
                c.scl_oe = 1'b0;
                c.state  = PH_SP_C;
                s_ld     = 1'b1;
            end
            PH_SP_C: begin
                if (scl_in) begin
                    c.state = PH_SP_D;
                    t_ld    = 1'b1;
                    t_val   = TW'(T_SETUP);
                end else if (s_exp) c = wrap_up(c, ST_TMO);
            end
            PH_SP_D: if (t_exp) begin
                c.sda_oe = 1'b0;
                c.state  = PH_SP_E;
                s_ld     = 1'b1;
            end
            PH_SP_E: begin
                if (sda_in)     c = wrap_up(c, q.pend);
                else if (s_exp) c = wrap_up(c, ST_TMO);
            end
            default: c = wrap_up(c, ST_TMO);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.state  <= PH_IDLE;
            q.pend   <= ST_OK;
            q.status <= ST_OK;
        end else begin
            q <= c;
        end
    end

    assign scl_oe     = q.scl_oe;
    assign sda_oe     = q.sda_oe;
    assign done       = q.done;
    assign status     = q.status;
    assign xfer_count = q.sent;
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [7:0]       req_addr,
    input logic [CNT_W-1:0] req_count,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             scl_in,
    input logic             sda_in,
    input logic             done,
    input logic [7:0]       status
);
    AST_READ_REJECT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_addr[0] |=> done && status == 8'h20); // R1

    AST_LEN_REJECT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !req_addr[0] && int'(req_count) > 255
        |=> done && status == 8'h40); // R2

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done && status == 8'h01 |-> $past(!scl_in || !sda_in)); // R3

    AST_NO_REPULL_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
        !scl_oe && !scl_in |=> !scl_oe); // R6

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        done |-> !scl_oe && !sda_oe); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !scl_oe && !sda_oe); // R12
endmodule

bind i2c_wr_master i2cw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_in(scl_in), .sda_in(sda_in), .done(done), .status(status));

// File: tb/i2c_wr_master_bench.sv
`timescale 1ns/1ps
module i2c_wr_master_bench;
    localparam int CPU   = 10;
    localparam int SMAX  = 300;
    localparam int TSET  = (47 * CPU + 9) / 10;
    localparam int THIGH = (40 * CPU + 9) / 10;

    logic clk = 0, rst = 1;
    always #10 clk = ~clk;

    logic req_valid = 0, req_ready, data_valid = 0, data_ready;
    logic [7:0] req_addr = 0, data_byte = 0;
    logic [8:0] req_count = 0;
    logic scl_oe, sda_oe, done;
    logic [7:0] status, xfer_count;

    logic slv_scl_low = 0, slv_sda_low = 0, ext_scl_low = 0, ext_sda_low = 0, comp_low = 0;
    wire scl_line = !(scl_oe | slv_scl_low | ext_scl_low);
    wire sda_line = !(sda_oe | slv_sda_low | ext_sda_low | comp_low);

    i2c_wr_master #(.CLK_PER_US(CPU), .STRETCH_MAX(SMAX), .CNT_W(9)) u_i2c_wr_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_count(req_count), .data_valid(data_valid),
        .data_ready(data_ready), .data_byte(data_byte), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .scl_in(scl_line), .sda_in(sda_line), .done(done), .status(status),
        .xfer_count(xfer_count));

    int n_run = 0, n_fail = 0;
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard queues
    int exp_st[$], exp_cnt[$];
    logic [7:0] exp_rx[$], tx_q[$];
    int dones = 0;

    // payload stream feeder
    logic take = 0;
    always @(posedge clk) take <= data_valid && data_ready;
    always @(negedge clk) begin
        if (take && tx_q.size() > 0) void'(tx_q.pop_front());
        data_valid = (tx_q.size() > 0);
        data_byte  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    end

    // target model
    int   nack_at = 1000, stretch = 0, scnt = 0, bidx = 0;
    logic p_scl = 1, p_sda = 1, active = 0, ackph = 0;
    logic [3:0] bitn = 0;
    logic [7:0] sr = 0;
    always @(posedge clk) begin
        p_scl <= scl_line;
        p_sda <= sda_line;
        if (slv_scl_low) begin
            if (scnt == 0) slv_scl_low <= 0; else scnt <= scnt - 1;
        end
        if (scl_line && p_scl && p_sda && !sda_line) begin
            active <= 1; bitn <= 0; bidx <= 0; ackph <= 0;
        end else if (scl_line && p_scl && !p_sda && sda_line) begin
            active <= 0; slv_sda_low <= 0;
        end else if (active) begin
            if (scl_line && !p_scl && !ackph) begin
                sr <= {sr[6:0], sda_line};
                bitn <= bitn + 1;
            end
            if (!scl_line && p_scl) begin
                if (stretch > 0) begin slv_scl_low <= 1; scnt <= stretch; end
                if (bitn == 8 && !ackph) begin
                    ackph <= 1;
                    bidx  <= bidx + 1;
                    if (bidx == 0) slv_sda_low <= (sr[7:1] == 7'h50);
                    else begin
                        slv_sda_low <= (bidx < nack_at);
                        if (exp_rx.size() == 0) check(0, "R5 extra byte", sr, 0);
                        else begin
                            check(sr == exp_rx[0], "R5 byte order", sr, exp_rx[0]);
                            void'(exp_rx.pop_front());
                        end
                    end
                end else if (ackph) begin
                    ackph <= 0; bitn <= 0; slv_sda_low <= 0;
                end
            end
        end
    end

    // line metrics: bus touched, START hold, SCL high / low phases
    logic touched = 0, hi_arm = 0, st_arm = 0;
    int hi_cnt = 0, hi_min = 1000000, lo_cnt = 0, lo_max = 0, st_cnt = 0, st_hold = -1;
    always @(posedge clk) begin
        if (scl_oe || sda_oe) touched <= 1;
        if (scl_line && !p_scl) begin hi_arm <= 1; hi_cnt <= 1; end
        else if (scl_line && hi_arm) hi_cnt <= hi_cnt + 1;
        else if (!scl_line && p_scl && hi_arm) begin
            hi_arm <= 0; if (hi_cnt < hi_min) hi_min <= hi_cnt;
        end
        if (!scl_line) lo_cnt <= lo_cnt + 1;
        else begin if (lo_cnt > lo_max) lo_max <= lo_cnt; lo_cnt <= 0; end
        if (scl_line && p_scl && p_sda && !sda_line && st_hold < 0) begin st_arm <= 1; st_cnt <= 0; end
        else if (st_arm && scl_line) st_cnt <= st_cnt + 1;
        else if (st_arm) begin st_arm <= 0; st_hold <= st_cnt; end
    end

    // monitor
    always @(negedge clk) if (!rst && done) begin
        dones++;
        if (exp_st.size() == 0) check(0, "R10 unexpected done", status, 0);
        else begin
            check(status == exp_st[0][7:0], "R10 status code", status, exp_st[0]);
            check(xfer_count == exp_cnt[0][7:0], "R9 byte count", xfer_count, exp_cnt[0]);
            check(!scl_oe && !sda_oe, "R10 lines released at done", {scl_oe, sda_oe}, 0);
            void'(exp_st.pop_front()); void'(exp_cnt.pop_front());
        end
    end

    logic [7:0] pay [0:3] = '{8'h5A, 8'hC3, 8'h01, 8'h80};

    task automatic run(input logic [7:0] a, input int n, input int st, input int cnt, input int nrx);
        int d0 = dones;
        tx_q.delete(); exp_rx.delete();
        for (int i = 0; i < n && i < 4; i++) tx_q.push_back(pay[i]);
        for (int i = 0; i < nrx; i++) exp_rx.push_back(pay[i]);
        exp_st.push_back(st); exp_cnt.push_back(cnt);
        @(negedge clk);
        touched = 0; hi_min = 1000000; lo_max = 0; st_hold = -1;
        req_addr = a; req_count = 9'(n); req_valid = 1;
        @(posedge clk); while (!req_ready) @(posedge clk);
        @(negedge clk); req_valid = 0;
        while (dones == d0) @(negedge clk);
        repeat (20) @(negedge clk);
        check(exp_rx.size() == 0, "R5 bytes missing at target", exp_rx.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R10 watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!scl_oe && !sda_oe && req_ready && !done, "R12 reset state",
              {scl_oe, sda_oe, req_ready, done}, 4'b0010);

        run(8'hA1, 2, 8'h20, 0, 0);                         // R1
        check(!touched, "R1 bus untouched", touched, 0);
        run(8'hA0, 300, 8'h40, 0, 0);                       // R2
        check(!touched, "R2 bus untouched", touched, 0);
        ext_sda_low = 1;
        run(8'hA0, 2, 8'h01, 0, 0);                         // R3
        check(!touched, "R3 bus untouched", touched, 0);
        ext_sda_low = 0;
        repeat (10) @(negedge clk);

        run(8'hA0, 4, 8'h00, 4, 4);                         // R10, R5
        check(st_hold >= TSET, "R4 START hold", st_hold, TSET);
        check(hi_min >= THIGH, "R6 SCL high phase", hi_min, THIGH);

        run(8'hA0, 0, 8'h00, 0, 0);                         // R10 address only
        run(8'h44, 2, 8'h02, 0, 0);                         // R8

        nack_at = 2;
        run(8'hA0, 4, 8'h04, 1, 2);                         // R9
        nack_at = 1000;

        stretch = 100;
        run(8'hA0, 2, 8'h00, 2, 2);                         // R6 stretched
        check(lo_max >= 100, "R6 stretch honoured", lo_max, 100);
        check(hi_min >= THIGH, "R6 high after stretch", hi_min, THIGH);
        stretch = 0;

        fork
            run(8'hA0, 2, 8'h08, 0, 0);                     // R7
            begin
                @(posedge sda_oe); @(negedge clk); comp_low = 1;
            end
        join
        check(!scl_oe && !sda_oe, "R7 no STOP, lines free", {scl_oe, sda_oe}, 0);
        comp_low = 0;
        repeat (10) @(negedge clk);

        fork
            run(8'hA0, 2, 8'h10, 0, 0);                     // R11
            begin
                @(posedge scl_oe); @(negedge clk); ext_scl_low = 1;
            end
        join
        ext_scl_low = 0;
        repeat (10) @(negedge clk);

        check(exp_st.size() == 0, "R12 all requests completed", exp_st.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule